// File: doc/BRIEF.md
# ADC Selection Shadow and Conversion Sequencer

This block holds the input-channel and reference selection that software programs for an analog-to-digital converter, and it decides when that selection reaches the converter. Software writes a 4-bit channel and a 3-bit reference into a register that it can read back at any time. A second copy, the shadow, is what the converter uses. While no conversion runs, the shadow takes the register value on every ADC clock tick. During a conversion the shadow is frozen, and it opens again only at the edge that ends the conversion.

The block also runs the conversion itself. A start strobe arms a conversion, which begins at the next ADC tick, lasts a fixed number of ticks and then sets a sticky completion flag. The flag is set in the same edge that captures the result input. In free-running mode the next conversion begins at once. A result whose reference differs from the one used by the previous completed conversion carries a discard hint. Dropping the enable aborts any activity.

The ADC clock is an `adc_tick` enable, one system clock wide. All state changes on the rising edge of `clk`.

Top module: `adc_sel_shadow`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, every output is 0.
- R2: A `sel_wr` pulse loads `sel_ch_wdata` and `sel_ref_wdata` into `sel_ch_q` and `sel_ref_q` on the next clock edge. This holds even while a conversion runs.
- R3: While no conversion is active, or while `en` is low, each `adc_tick` edge copies the register value into `shd_ch` and `shd_ref`.
- R4: With `en` high, a `start_wr` pulse sets `start_q` on the next edge. `conv_active` rises on the first `adc_tick` edge after that edge.
- R5: While a conversion is active, the shadow does not change, except at the edge that ends the conversion. Register writes made during the conversion do not reach the shadow before that edge.
- R6: A conversion spans exactly 13 `adc_tick` edges with `conv_active` high. The 13th of these edges sets `done_flag`.
- R7: The edge that sets `done_flag` also loads `result_q` from `res_in` and copies the register value into the shadow.
- R8: With `free_run` low, `start_q` and `conv_active` are both 0 after the completing edge.
- R9: With `free_run` high, a new conversion starts at the completing edge and uses the shadow loaded there. A selection written after a completion therefore first appears in the shadow when the conversion after the restarted one begins.
- R10: On completion, `discard_hint` becomes 1 if the reference used differs from the reference of the previous completed conversion, and 0 otherwise. The reference before the first conversion counts as 0.
- R11: `done_flag` stays 1 until a `flag_clr_wr` pulse clears it on the next edge. A completion in the same edge wins over the clear.
- R12: With `en` low, `conv_active` and `start_q` are 0 after the next edge and the tick count returns to idle. `start_wr` is ignored while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_tick | input | 1 | ADC clock enable, one cycle wide |
| en | input | 1 | Converter enable |
| free_run | input | 1 | Restart automatically after each completion |
| start_wr | input | 1 | Strobe: write 1 to the start bit |
| flag_clr_wr | input | 1 | Strobe: write 1 to clear the completion flag |
| sel_wr | input | 1 | Strobe: write the selection register |
| sel_ch_wdata | input | 4 | Channel value to write |
| sel_ref_wdata | input | 3 | Reference value to write |
| res_in | input | 10 | Quantiser result, captured at completion |
| sel_ch_q | output | 4 | Register channel readback |
| sel_ref_q | output | 3 | Register reference readback |
| shd_ch | output | 4 | Shadow channel used by the converter |
| shd_ref | output | 3 | Shadow reference used by the converter |
| start_q | output | 1 | Start bit readback: armed or converting |
| conv_active | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky completion flag |
| result_q | output | 10 | Captured conversion result |
| discard_hint | output | 1 | Result follows a reference change |

## Verification
The assertions check the following on every cycle:
- the shadow is frozen inside a conversion;
- the flag is set by a completion and cleared by its strobe;
- the start bit clears after a single-shot completion;
- the abort takes effect when enable drops;
- the tick count stays in range;
- register writes are loaded.

Some behaviours only the bench scenarios can show. These are the exact 13-tick length, the free-running case where a selection written after a completion misses the restarted conversion, and the discard hint across a reference change. The bench runs a behavioural model next to the design and compares every output on every clock.

// File: rtl/adc_sel_pkg.sv
package adc_sel_pkg;
  parameter int CH_W  = 4;
  parameter int REF_W = 3;

  typedef struct packed {
    logic [REF_W-1:0] refsel;
    logic [CH_W-1:0]  ch;
  } sel_t;
endpackage

// File: rtl/adc_sel_regs.sv
module adc_sel_regs
  import adc_sel_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  sel_t wdata,
  input  logic open_en,
  output sel_t cpu_q,
  output sel_t shd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_q <= '0;
      shd_q <= '0;
    end else begin
      if (wr) cpu_q <= wdata;
      if (open_en) shd_q <= cpu_q;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int CONV_CYC = 13,
  localparam int CNT_W = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             free_run,
  input  logic             start_wr,
  output logic             pend,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last,
  output logic             cmp
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC - 1);

  assign at_last = active && (cnt == LAST);
  assign cmp     = en && tick && at_last;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pend   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      if (start_wr && !active) pend <= 1'b1;
      if (tick) begin
        if (active) begin
          if (cnt == LAST) begin
            cnt    <= '0;
            active <= free_run;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (pend) begin
          active <= 1'b1;
          cnt    <= '0;
          pend   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_result_cap.sv
module adc_result_cap #(
  parameter int RES_W = 10,
  parameter int REF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp,
  input  logic             flag_clr,
  input  logic [RES_W-1:0] res_in,
  input  logic [REF_W-1:0] conv_ref,
  output logic             flag,
  output logic [RES_W-1:0] result,
  output logic             discard
);
  logic [REF_W-1:0] prev_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      result   <= '0;
      discard  <= 1'b0;
      prev_ref <= '0;
    end else if (cmp) begin
      flag     <= 1'b1;
      result   <= res_in;
      discard  <= (conv_ref != prev_ref);
      prev_ref <= conv_ref;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow
  import adc_sel_pkg::*;
#(
  parameter int CONV_CYC = 13,
  parameter int RES_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adc_tick,
  input  logic             en,
  input  logic             free_run,
  input  logic             start_wr,
  input  logic             flag_clr_wr,
  input  logic             sel_wr,
  input  logic [CH_W-1:0]  sel_ch_wdata,
  input  logic [REF_W-1:0] sel_ref_wdata,
  input  logic [RES_W-1:0] res_in,
  output logic [CH_W-1:0]  sel_ch_q,
  output logic [REF_W-1:0] sel_ref_q,
  output logic [CH_W-1:0]  shd_ch,
  output logic [REF_W-1:0] shd_ref,
  output logic             start_q,
  output logic             conv_active,
  output logic             done_flag,
  output logic [RES_W-1:0] result_q,
  output logic             discard_hint
);
  localparam int CNT_W = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;

  sel_t             wsel, cpu_sel, shd_sel;
  logic             pend, active, at_last, cmp, shd_open;
  logic [CNT_W-1:0] cnt_q;

  assign wsel     = '{refsel: sel_ref_wdata, ch: sel_ch_wdata};
  assign shd_open = adc_tick && (!active || at_last || !en);

  adc_sel_regs u_regs (
    .clk(clk), .rst(rst), .wr(sel_wr), .wdata(wsel),
    .open_en(shd_open), .cpu_q(cpu_sel), .shd_q(shd_sel)
  );

  adc_conv_seq #(.CONV_CYC(CONV_CYC)) u_seq (
    .clk(clk), .rst(rst), .tick(adc_tick), .en(en), .free_run(free_run),
    .start_wr(start_wr), .pend(pend), .active(active), .cnt(cnt_q),
    .at_last(at_last), .cmp(cmp)
  );

  adc_result_cap #(.RES_W(RES_W), .REF_W(REF_W)) u_cap (
    .clk(clk), .rst(rst), .cmp(cmp), .flag_clr(flag_clr_wr),
    .res_in(res_in), .conv_ref(shd_sel.refsel),
    .flag(done_flag), .result(result_q), .discard(discard_hint)
  );

  assign sel_ch_q    = cpu_sel.ch;
  assign sel_ref_q   = cpu_sel.refsel;
  assign shd_ch      = shd_sel.ch;
  assign shd_ref     = shd_sel.refsel;
  assign start_q     = pend || active;
  assign conv_active = active;
endmodule

// File: rtl/adc_sel_shadow_chk.sv
module adc_sel_shadow_chk #(
  parameter int CNT_W = 4,
  parameter int LAST  = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             adc_tick,
  input logic             en,
  input logic             free_run,
  input logic             flag_clr_wr,
  input logic             sel_wr,
  input logic [3:0]       sel_ch_wdata,
  input logic [3:0]       sel_ch_q,
  input logic [3:0]       shd_ch,
  input logic [2:0]       shd_ref,
  input logic             start_q,
  input logic             conv_active,
  input logic             done_flag,
  input logic             cmp,
  input logic             at_last,
  input logic [CNT_W-1:0] cnt_q
);
  a_r5_shadow_frozen: assert property (@(posedge clk) disable iff (rst)
    (conv_active && en && !(adc_tick && at_last)) |=> ($stable(shd_ch) && $stable(shd_ref)));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
    cmp |=> done_flag);

  a_r11_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_wr && !cmp) |=> !done_flag);

  a_r8_single_clear: assert property (@(posedge clk) disable iff (rst)
    (cmp && !free_run) |=> !start_q);

  a_r12_abort: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!conv_active && !start_q));

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (32'(cnt_q) <= LAST));

  a_r2_reg_load: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> (sel_ch_q == $past(sel_ch_wdata)));
endmodule

bind adc_sel_shadow adc_sel_shadow_chk #(.CNT_W(CNT_W), .LAST(CONV_CYC - 1)) u_chk (
  .clk(clk), .rst(rst), .adc_tick(adc_tick), .en(en), .free_run(free_run),
  .flag_clr_wr(flag_clr_wr), .sel_wr(sel_wr), .sel_ch_wdata(sel_ch_wdata),
  .sel_ch_q(sel_ch_q), .shd_ch(shd_ch), .shd_ref(shd_ref), .start_q(start_q),
  .conv_active(conv_active), .done_flag(done_flag), .cmp(cmp),
  .at_last(at_last), .cnt_q(cnt_q)
);

// File: tb/adc_sel_shadow_tb.sv
module adc_sel_shadow_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 13;

  logic clk = 1'b0, rst = 1'b1;
  logic adc_tick = 0, en = 0, free_run = 0, start_wr = 0, flag_clr_wr = 0, sel_wr = 0;
  logic [3:0] sel_ch_wdata = 0;
  logic [2:0] sel_ref_wdata = 0;
  logic [9:0] res_in = 0;
  logic [3:0] sel_ch_q, shd_ch;
  logic [2:0] sel_ref_q, shd_ref;
  logic start_q, conv_active, done_flag, discard_hint;
  logic [9:0] result_q;

  int vecs = 0, errs = 0, ph = 0;
  bit chk_on = 0, ended = 0;

  // behavioural model state
  int m_cch, m_cref, m_sch, m_sref, m_cnt, m_res, m_prev;
  bit m_pend, m_run, m_flag, m_disc;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_sel_shadow u_dut (
    .clk(clk), .rst(rst), .adc_tick(adc_tick), .en(en), .free_run(free_run),
    .start_wr(start_wr), .flag_clr_wr(flag_clr_wr), .sel_wr(sel_wr),
    .sel_ch_wdata(sel_ch_wdata), .sel_ref_wdata(sel_ref_wdata), .res_in(res_in),
    .sel_ch_q(sel_ch_q), .sel_ref_q(sel_ref_q), .shd_ch(shd_ch), .shd_ref(shd_ref),
    .start_q(start_q), .conv_active(conv_active), .done_flag(done_flag),
    .result_q(result_q), .discard_hint(discard_hint)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_cch = 0; m_cref = 0; m_sch = 0; m_sref = 0; m_cnt = 0; m_res = 0; m_prev = 0;
      m_pend = 0; m_run = 0; m_flag = 0; m_disc = 0;
    end else begin
      automatic bit done_now = en && adc_tick && m_run && (m_cnt == NCYC - 1);
      automatic bit opn = adc_tick && (!m_run || m_cnt == NCYC - 1 || !en);
      if (done_now) begin
        m_flag = 1; m_res = int'(res_in); m_disc = (m_sref != m_prev); m_prev = m_sref;
      end else if (flag_clr_wr) m_flag = 0;
      if (opn) begin m_sch = m_cch; m_sref = m_cref; end
      if (sel_wr) begin m_cch = int'(sel_ch_wdata); m_cref = int'(sel_ref_wdata); end
      if (!en) begin m_pend = 0; m_run = 0; m_cnt = 0; end
      else begin
        automatic bit p_old = m_pend;
        if (start_wr && !m_run) m_pend = 1;
        if (adc_tick) begin
          if (m_run) begin
            if (m_cnt == NCYC - 1) begin m_cnt = 0; m_run = free_run; end
            else m_cnt++;
          end else if (p_old) begin m_run = 1; m_cnt = 0; m_pend = 0; end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !ended) begin
      chk("R2 sel_ch_q", int'(sel_ch_q), m_cch);
      chk("R2 sel_ref_q", int'(sel_ref_q), m_cref);
      chk("R3 R5 R7 shd_ch", int'(shd_ch), m_sch);
      chk("R3 R5 R7 shd_ref", int'(shd_ref), m_sref);
      chk("R4 R8 start_q", int'(start_q), int'(m_pend || m_run));
      chk("R6 R9 conv_active", int'(conv_active), int'(m_run));
      chk("R11 done_flag", int'(done_flag), int'(m_flag));
      chk("R7 result_q", int'(result_q), m_res);
      chk("R10 discard_hint", int'(discard_hint), int'(m_disc));
    end
  end

  task automatic step();
    @(negedge clk);
    ph++;
    adc_tick = (ph % 3 == 0);
    res_in = 10'(ph * 37 + 5);
  endtask

  task automatic stepn(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_sel(int c, int r);
    sel_ch_wdata = 4'(c); sel_ref_wdata = 3'(r); sel_wr = 1; step(); sel_wr = 0;
  endtask

  task automatic pulse_start();
    start_wr = 1; step(); start_wr = 0;
  endtask

  task automatic pulse_clr();
    flag_clr_wr = 1; step(); flag_clr_wr = 0;
  endtask

  task automatic wait_done(output int ticks);
    ticks = 0;
    for (int i = 0; i < 300 && !done_flag; i++) begin
      if (adc_tick && conv_active) ticks++;
      step();
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t;
    stepn(3);
    rst = 0;
    step();
    chk_on = 1;
    // R1: reset state
    chk("R1 outputs", int'({shd_ch, sel_ch_q, start_q, conv_active, done_flag, result_q, discard_hint}), 0);
    en = 1;
    wr_sel(5, 1);
    chk("R2 register load", int'(sel_ch_q), 5);
    stepn(4);
    chk("R3 idle shadow follows", int'(shd_ch), 5);
    pulse_start();
    chk("R4 start bit set", int'(start_q), 1);
    stepn(3);
    chk("R4 conversion began", int'(conv_active), 1);
    wr_sel(9, 1);
    stepn(6);
    chk("R5 shadow frozen", int'(shd_ch), 5);
    wait_done(t);
    chk("R6 tick length", t + 2, NCYC);  // two ticks already spent before wait
    chk("R7 shadow reopened at completion", int'(shd_ch), 9);
    chk("R8 start bit cleared", int'(start_q), 0);
    chk("R10 ref change flagged", int'(discard_hint), 1);
    pulse_clr();
    chk("R11 flag cleared", int'(done_flag), 0);
    stepn(2);
    chk("R11 flag stays clear", int'(done_flag), 0);
    // exact length measured from start
    pulse_start();
    wait_done(t);
    chk("R6 full length", t, NCYC);
    chk("R10 same ref not flagged", int'(discard_hint), 0);
    pulse_clr();
    // free-running
    wr_sel(3, 1);
    stepn(4);
    free_run = 1;
    pulse_start();
    wait_done(t);
    pulse_clr();
    sel_ch_wdata = 4'd7; sel_ref_wdata = 3'd1; sel_wr = 1; step(); sel_wr = 0;
    stepn(3);
    chk("R9 restarted", int'(conv_active), 1);
    chk("R9 restarted uses old selection", int'(shd_ch), 3);
    wait_done(t);
    chk("R9 new selection at next restart", int'(shd_ch), 7);
    // abort
    en = 0; step();
    chk("R12 abort active", int'(conv_active), 0);
    chk("R12 abort start bit", int'(start_q), 0);
    pulse_start();
    stepn(4);
    chk("R12 start ignored when disabled", int'(start_q), 0);
    free_run = 0; en = 1;
    stepn(20);
    chk("R12 stays idle", int'(conv_active), 0);
    finish_run();
  end
endmodule